// File: doc/BRIEF.md
# Time-Switch Processor Access Port

This block is the processor-facing port of a time-slot switch. It presents an 8-bit, non-multiplexed bus with a 6-bit address, an active-low chip select, an active-high data strobe, a read/write line and an active-low acknowledge. A single address line picks between the control register and a 32-byte window into the switch memories. The window is paged by a stream field in the control register, so one of eight streams of 32 channels is visible at a time. The block owns the data memory, the connection-low memory and the connection-high memory, 256 bytes each.

The serial side of the switch uses the same memories. A free-running slot timer reserves three fixed cycles of every slot for it: a data-memory write, a data-memory read and a connection-memory read. A pending processor transfer waits for the next cycle the serial side does not own. The acknowledge delay therefore varies with the slot phase at which the transfer arrives.

A split mode in the control register sends reads to the data memory and writes to the connection memory chosen by the memory-select field. The processor-enable bit of the control register is passed to the switching datapath.

Top module: `tsw_cpu_port`

## Requirements
- R1: After reset the control register reads 0x00, `ack_n` is high, `rdata_oe` is low and `proc_en` is low.
- R2: When `addr[5]` is 0 the transfer targets the control register, whatever `addr[4:0]` holds. The fields are: bit 7 split, bit 6 processor enable, bit 5 unused, bits 4:3 memory select, bits 2:0 stream page. Bit 5 is stored as 0 and reads back as 0.
- R3: When `addr[5]` is 1 the transfer targets memory index {page, `addr[4:0]`}. Memory select 2'b10 picks connection-low, 2'b11 picks connection-high and 2'b01 picks the data memory. Locations in different pages are distinct.
- R4: With the split bit set, reads return the data memory and writes go to the connection memory named by memory select. This lasts until the control register is written again.
- R5: A write aimed at the data memory, or made while memory select is 2'b00, is acknowledged and changes no memory. A read made with memory select 2'b00 returns 0x00.
- R6: A transfer starts when `cs_n` is low and `strb` is high. `ack_n` then stays low until `strb` falls or `cs_n` rises. During a read acknowledge `rdata_oe` is high and `rdata` holds steady. `ack_n` never falls while `cs_n` is high.
- R7: A control-register transfer is acknowledged one clock after the request is sampled. A memory transfer is acknowledged within five clocks.
- R8: `slot_phase` counts 0 to SLOT_CYC-1 and then wraps. Phase 0 writes the data memory from `ser_dm_*`. Phase 1 loads `ser_dm_rdata` from `ser_dm_raddr`. Phase 2 loads `ser_cml_rdata` and `ser_cmh_rdata` from `ser_cm_raddr`. The processor never touches memory in phases 0 to 2.
- R9: `proc_en` equals bit 6 of the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip select, active low |
| strb | input | 1 | Data strobe, active high |
| rd_wr | input | 1 | 1 = read, 0 = write |
| addr | input | 6 | Bus address |
| wdata | input | 8 | Write data from the processor |
| rdata | output | 8 | Read data to the processor |
| rdata_oe | output | 1 | Drive enable for the read data bus |
| ack_n | output | 1 | Transfer acknowledge, active low (open-drain pull-down) |
| ser_dm_we | input | 1 | Serial-side data-memory write request |
| ser_dm_waddr | input | 8 | Serial-side data-memory write index |
| ser_dm_wdata | input | 8 | Serial-side data-memory write byte |
| ser_dm_raddr | input | 8 | Serial-side data-memory read index |
| ser_cm_raddr | input | 8 | Serial-side connection-memory read index |
| ser_dm_rdata | output | 8 | Data-memory byte loaded in phase 1 |
| ser_cml_rdata | output | 8 | Connection-low byte loaded in phase 2 |
| ser_cmh_rdata | output | 8 | Connection-high byte loaded in phase 2 |
| slot_phase | output | $clog2(SLOT_CYC) | Current cycle within the slot |
| proc_en | output | 1 | Processor-enable control bit |

## Verification
Some rules are checked by assertions on every cycle:
- the processor never writes a memory or is granted access during a serial-owned phase;
- the phase counter wraps;
- the control register holds its value unless it is written;
- `ack_n` stays low while the strobe is held, and read data stays steady during the acknowledge;
- a pending transfer waits no more than three cycles.

Other behaviour only the bench scenarios can show:
- address decode and page isolation;
- that a select value steers an access to the right memory, including split mode and ignored writes;
- control-register readback and `proc_en`;
- reset clearing;
- the measured acknowledge latencies.

// File: rtl/tsw_port_pkg.sv
package tsw_port_pkg;
  localparam int STREAM_W = 3;
  localparam int CHAN_W   = 5;
  localparam int IDX_W    = STREAM_W + CHAN_W;
  localparam int BYTE_W   = 8;
  localparam int ADDR_W   = CHAN_W + 1;
  localparam int SER_CYC  = 3;

  typedef enum logic [1:0] {
    MS_RSVD    = 2'b00,
    MS_DATA    = 2'b01,
    MS_CONN_LO = 2'b10,
    MS_CONN_HI = 2'b11
  } mem_sel_e;

  typedef struct packed {
    logic                split;
    logic                proc_en;
    logic                spare;
    mem_sel_e            msel;
    logic [STREAM_W-1:0] page;
  } ctrl_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_WAIT = 2'b01,
    ST_ACK  = 2'b10
  } bus_st_e;

  // Memory a transfer reaches: split mode redirects reads only.
  function automatic mem_sel_e target_sel(ctrl_t c, logic is_read);
    return (is_read && c.split) ? MS_DATA : c.msel;
  endfunction

  function automatic ctrl_t ctrl_from_byte(logic [BYTE_W-1:0] b);
    ctrl_t c;
    c       = ctrl_t'(b);
    c.spare = 1'b0;
    return c;
  endfunction

  function automatic logic [IDX_W-1:0] mem_index(logic [STREAM_W-1:0] page,
                                                 logic [CHAN_W-1:0] chan);
    return {page, chan};
  endfunction
endpackage

// File: rtl/tsw_ram.sv
module tsw_ram #(
  parameter int AW = 8,
  parameter int DW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/tsw_slot_timer.sv
module tsw_slot_timer #(
  parameter int SLOT_CYC = 8,
  parameter int SER_CYC  = 3,
  localparam int PW = $clog2(SLOT_CYC)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [PW-1:0] phase,
  output logic          ph_dm_wr,
  output logic          ph_dm_rd,
  output logic          ph_cm_rd,
  output logic          ph_free
);
  localparam logic [PW-1:0] LAST = PW'(SLOT_CYC - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             phase <= '0;
    else if (phase == LAST) phase <= '0;
    else                    phase <= phase + 1'b1;
  end

  assign ph_dm_wr = (phase == PW'(0));
  assign ph_dm_rd = (phase == PW'(1));
  assign ph_cm_rd = (phase == PW'(2));
  assign ph_free  = (phase >= PW'(SER_CYC));

  p_phase_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == LAST) |=> (phase == PW'(0)));
endmodule

// File: rtl/tsw_ctrl_reg.sv
module tsw_ctrl_reg
  import tsw_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [BYTE_W-1:0] wbyte,
  output ctrl_t             q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= ctrl_from_byte(wbyte);
  end

  // Split and page settings persist until the next register write.
  p_ctrl_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));
endmodule

// File: rtl/tsw_bus_fsm.sv
module tsw_bus_fsm
  import tsw_port_pkg::*;
#(
  parameter int SLOT_CYC = 8,
  localparam int WC_W = $clog2(SLOT_CYC) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              strb,
  input  logic              rd_wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              free_slot,
  input  logic [BYTE_W-1:0] ctrl_byte,
  input  logic [BYTE_W-1:0] mem_byte,
  output logic [ADDR_W-1:0] lat_addr,
  output logic              lat_rd,
  output logic [BYTE_W-1:0] lat_wdata,
  output logic              ctrl_we,
  output logic              mem_go,
  output logic [BYTE_W-1:0] rdata,
  output logic              rdata_oe,
  output logic              ack_n
);
  bus_st_e          state;
  logic [WC_W-1:0]  wait_cnt;
  logic             start;
  logic             is_ctrl;

  assign start   = !cs_n && strb;
  assign is_ctrl = !addr[ADDR_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      lat_addr  <= '0;
      lat_rd    <= 1'b0;
      lat_wdata <= '0;
      rdata     <= '0;
      wait_cnt  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          lat_addr  <= addr;
          lat_rd    <= rd_wr;
          lat_wdata <= wdata;
          wait_cnt  <= '0;
          if (is_ctrl) begin
            if (rd_wr) rdata <= ctrl_byte;
            state <= ST_ACK;
          end else begin
            state <= ST_WAIT;
          end
        end
        ST_WAIT: if (free_slot) begin
          if (lat_rd) rdata <= mem_byte;
          state <= ST_ACK;
        end else begin
          wait_cnt <= wait_cnt + 1'b1;
        end
        ST_ACK: if (!strb || cs_n) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign ctrl_we  = (state == ST_IDLE) && start && is_ctrl && !rd_wr;
  assign mem_go   = (state == ST_WAIT) && free_slot;
  assign ack_n    = (state != ST_ACK);
  assign rdata_oe = (state == ST_ACK) && lat_rd;

  p_ack_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_n && strb && !cs_n) |=> !ack_n);
  p_rdata_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_n && $past(!ack_n)) |-> $stable(rdata));
  p_wait_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wait_cnt <= WC_W'(SER_CYC));
endmodule

// File: rtl/tsw_cpu_port.sv
module tsw_cpu_port
  import tsw_port_pkg::*;
#(
  parameter int SLOT_CYC = 8,
  localparam int PW = $clog2(SLOT_CYC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              strb,
  input  logic              rd_wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic              rdata_oe,
  output logic              ack_n,
  input  logic              ser_dm_we,
  input  logic [IDX_W-1:0]  ser_dm_waddr,
  input  logic [BYTE_W-1:0] ser_dm_wdata,
  input  logic [IDX_W-1:0]  ser_dm_raddr,
  input  logic [IDX_W-1:0]  ser_cm_raddr,
  output logic [BYTE_W-1:0] ser_dm_rdata,
  output logic [BYTE_W-1:0] ser_cml_rdata,
  output logic [BYTE_W-1:0] ser_cmh_rdata,
  output logic [PW-1:0]     slot_phase,
  output logic              proc_en
);
  logic ph_dm_wr, ph_dm_rd, ph_cm_rd, ph_free;
  ctrl_t ctrl;
  logic [ADDR_W-1:0] lat_addr;
  logic [BYTE_W-1:0] lat_wdata;
  logic lat_rd, ctrl_we, mem_go;
  mem_sel_e tgt;
  logic [IDX_W-1:0] proc_idx, dm_raddr, cm_raddr;
  logic [BYTE_W-1:0] dm_q, cml_q, cmh_q, mem_byte;
  logic dm_we, cml_we, cmh_we;

  tsw_slot_timer #(.SLOT_CYC(SLOT_CYC), .SER_CYC(SER_CYC)) timer_i (
    .clk(clk), .rst_n(rst_n), .phase(slot_phase),
    .ph_dm_wr(ph_dm_wr), .ph_dm_rd(ph_dm_rd), .ph_cm_rd(ph_cm_rd), .ph_free(ph_free)
  );

  tsw_ctrl_reg ctrl_i (
    .clk(clk), .rst_n(rst_n), .we(ctrl_we), .wbyte(wdata), .q(ctrl)
  );

  tsw_bus_fsm #(.SLOT_CYC(SLOT_CYC)) fsm_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .strb(strb), .rd_wr(rd_wr),
    .addr(addr), .wdata(wdata), .free_slot(ph_free),
    .ctrl_byte(BYTE_W'(ctrl)), .mem_byte(mem_byte),
    .lat_addr(lat_addr), .lat_rd(lat_rd), .lat_wdata(lat_wdata),
    .ctrl_we(ctrl_we), .mem_go(mem_go),
    .rdata(rdata), .rdata_oe(rdata_oe), .ack_n(ack_n)
  );

  assign proc_en  = ctrl.proc_en;
  assign tgt      = target_sel(ctrl, lat_rd);
  assign proc_idx = mem_index(ctrl.page, lat_addr[CHAN_W-1:0]);

  // Serial side owns the read ports in its fixed phases.
  assign dm_raddr = ph_dm_rd ? ser_dm_raddr : proc_idx;
  assign cm_raddr = ph_cm_rd ? ser_cm_raddr : proc_idx;

  // The data memory is written only by the serial side.
  assign dm_we  = ph_dm_wr && ser_dm_we;
  assign cml_we = mem_go && !lat_rd && (tgt == MS_CONN_LO);
  assign cmh_we = mem_go && !lat_rd && (tgt == MS_CONN_HI);

  always_comb begin
    unique case (tgt)
      MS_DATA:    mem_byte = dm_q;
      MS_CONN_LO: mem_byte = cml_q;
      MS_CONN_HI: mem_byte = cmh_q;
      default:    mem_byte = '0;
    endcase
  end

  tsw_ram #(.AW(IDX_W), .DW(BYTE_W)) dm_i (
    .clk(clk), .we(dm_we), .waddr(ser_dm_waddr), .wdata(ser_dm_wdata),
    .raddr(dm_raddr), .rdata(dm_q)
  );
  tsw_ram #(.AW(IDX_W), .DW(BYTE_W)) cml_i (
    .clk(clk), .we(cml_we), .waddr(proc_idx), .wdata(lat_wdata),
    .raddr(cm_raddr), .rdata(cml_q)
  );
  tsw_ram #(.AW(IDX_W), .DW(BYTE_W)) cmh_i (
    .clk(clk), .we(cmh_we), .waddr(proc_idx), .wdata(lat_wdata),
    .raddr(cm_raddr), .rdata(cmh_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ser_dm_rdata  <= '0;
      ser_cml_rdata <= '0;
      ser_cmh_rdata <= '0;
    end else begin
      if (ph_dm_rd) ser_dm_rdata <= dm_q;
      if (ph_cm_rd) begin
        ser_cml_rdata <= cml_q;
        ser_cmh_rdata <= cmh_q;
      end
    end
  end

  p_cm_write_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cml_we || cmh_we) |-> (slot_phase >= PW'(SER_CYC)));
  p_grant_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_go |-> (slot_phase >= PW'(SER_CYC)));
  p_dm_serial_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dm_we |-> (ser_dm_we && slot_phase == PW'(0)));
  p_no_ack_unselected_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ack_n)) |-> $past(!cs_n));
endmodule

// File: tb/tsw_cpu_port_tb.sv
module tsw_cpu_port_tb_top;
  localparam int SLOT_CYC = 8;
  localparam int NV = 28;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, strb = 1'b0, rd_wr = 1'b0;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic rdata_oe, ack_n;
  logic ser_dm_we = 1'b0;
  logic [7:0] ser_dm_waddr = '0, ser_dm_wdata = '0, ser_dm_raddr = '0, ser_cm_raddr = '0;
  logic [7:0] ser_dm_rdata, ser_cml_rdata, ser_cmh_rdata;
  logic [2:0] slot_phase;
  logic proc_en;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tsw_cpu_port #(.SLOT_CYC(SLOT_CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .strb(strb), .rd_wr(rd_wr),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe), .ack_n(ack_n),
    .ser_dm_we(ser_dm_we), .ser_dm_waddr(ser_dm_waddr), .ser_dm_wdata(ser_dm_wdata),
    .ser_dm_raddr(ser_dm_raddr), .ser_cm_raddr(ser_cm_raddr),
    .ser_dm_rdata(ser_dm_rdata), .ser_cml_rdata(ser_cml_rdata),
    .ser_cmh_rdata(ser_cmh_rdata), .slot_phase(slot_phase), .proc_en(proc_en)
  );

  // {read, addr, wdata, expected read byte}
  localparam logic [22:0] VEC [NV] = '{
    {1'b0, 6'h00, 8'h13, 8'h00},  // page 3, connection-low (R2)
    {1'b0, 6'h25, 8'hA5, 8'h00},
    {1'b1, 6'h25, 8'h00, 8'hA5},  // R3
    {1'b0, 6'h00, 8'h1B, 8'h00},  // connection-high
    {1'b0, 6'h25, 8'h42, 8'h00},
    {1'b1, 6'h25, 8'h00, 8'h42},  // R3
    {1'b0, 6'h00, 8'h13, 8'h00},
    {1'b1, 6'h25, 8'h00, 8'hA5},  // low kept apart from high (R3)
    {1'b1, 6'h00, 8'h00, 8'h13},  // readback (R2)
    {1'b0, 6'h1E, 8'hF2, 8'h00},  // low address bits ignored, bit 5 dropped (R2)
    {1'b1, 6'h07, 8'h00, 8'hD2},
    {1'b1, 6'h25, 8'h00, 8'h5C},  // split read from data memory (R4)
    {1'b0, 6'h25, 8'h77, 8'h00},  // split write to connection-low (R4)
    {1'b0, 6'h00, 8'h12, 8'h00},
    {1'b1, 6'h25, 8'h00, 8'h77},  // R4
    {1'b0, 6'h00, 8'h0A, 8'h00},  // data memory select
    {1'b0, 6'h25, 8'h99, 8'h00},  // ignored (R5)
    {1'b1, 6'h25, 8'h00, 8'h5C},  // R5
    {1'b0, 6'h00, 8'h02, 8'h00},  // reserved select
    {1'b1, 6'h25, 8'h00, 8'h00},  // R5
    {1'b0, 6'h25, 8'h33, 8'h00},  // ignored (R5)
    {1'b0, 6'h00, 8'h12, 8'h00},
    {1'b1, 6'h25, 8'h00, 8'h77},  // R5
    {1'b0, 6'h00, 8'h1A, 8'h00},
    {1'b0, 6'h25, 8'h66, 8'h00},
    {1'b1, 6'h25, 8'h00, 8'h66},  // page 2 high (R3)
    {1'b0, 6'h00, 8'h13, 8'h00},
    {1'b1, 6'h25, 8'h00, 8'hA5}   // page 3 untouched by page 2 (R3)
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_xfer(input logic rd, input logic [5:0] a, input logic [7:0] d,
                          input int hold, output logic [7:0] q, output int lat,
                          output logic oe);
    @(negedge clk);
    cs_n = 1'b0; strb = 1'b1; rd_wr = rd; addr = a; wdata = d; lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (ack_n && lat < 40);
    q  = rdata;
    oe = rdata_oe;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      chk(!ack_n && rdata == q, "R6 ack held while strobe high", {23'd0, ack_n}, 0);
    end
    strb = 1'b0; cs_n = 1'b1;
    @(negedge clk);
    chk(ack_n && !rdata_oe, "R6 release after strobe falls", {ack_n, rdata_oe}, 2);
  endtask

  task automatic ser_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    ser_dm_we = 1'b1; ser_dm_waddr = a; ser_dm_wdata = d;
    repeat (SLOT_CYC) @(negedge clk);
    ser_dm_we = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] q;
    int lat;
    logic oe;
    logic [2:0] pprev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(ack_n === 1'b1, "R1 ack_n after reset", ack_n, 1);
    chk(rdata_oe === 1'b0, "R1 rdata_oe after reset", rdata_oe, 0);
    chk(proc_en === 1'b0, "R1 proc_en after reset", proc_en, 0);
    // R8 phase sequence
    pprev = slot_phase;
    for (int k = 0; k < SLOT_CYC + 2; k++) begin
      @(negedge clk);
      chk(slot_phase == 3'(pprev + 1), "R8 slot phase step", slot_phase, 3'(pprev + 1));
      pprev = slot_phase;
    end
    bus_xfer(1'b1, 6'h00, 8'h00, 0, q, lat, oe);
    chk(q == 8'h00, "R1 control register cleared", q, 0);
    // R7 control-register latency
    chk(lat == 1, "R7 control ack latency", lat, 1);

    // preload data memory through the serial side, then read it back there (R8)
    ser_write(8'd69, 8'h5C);
    @(negedge clk); ser_dm_raddr = 8'd69;
    repeat (SLOT_CYC + 1) @(negedge clk);
    chk(ser_dm_rdata == 8'h5C, "R8 serial data-memory read", ser_dm_rdata, 8'h5C);

    for (int i = 0; i < NV; i++) begin
      logic [22:0] v;
      v = VEC[i];
      bus_xfer(v[22], v[21:16], v[15:8], 0, q, lat, oe);
      chk(lat <= 5, "R7 ack latency bound", lat, 5);
      if (v[22]) begin
        if (q != v[7:0])
          $display("FAIL R3/R4/R5 vector %0d read actual=0x%0h expected=0x%0h", i, q, v[7:0]);
        n_chk++;
        if (q != v[7:0]) n_bad++;
        chk(oe, "R6 rdata_oe during read ack", {31'd0, oe}, 1);
      end
    end

    // serial connection-memory port sees processor writes (R8, R3)
    @(negedge clk); ser_cm_raddr = 8'd101;
    repeat (SLOT_CYC + 1) @(negedge clk);
    chk(ser_cml_rdata == 8'hA5, "R8 serial connection-low read", ser_cml_rdata, 8'hA5);
    chk(ser_cmh_rdata == 8'h42, "R8 serial connection-high read", ser_cmh_rdata, 8'h42);

    // R6 strobe held long: ack and data stay
    bus_xfer(1'b1, 6'h25, 8'h00, 6, q, lat, oe);
    chk(q == 8'hA5, "R6 long-held read", q, 8'hA5);

    // R6 strobe with chip select high is ignored
    @(negedge clk); cs_n = 1'b1; strb = 1'b1; rd_wr = 1'b0; addr = 6'h00; wdata = 8'hFF;
    repeat (10) begin
      @(negedge clk);
      chk(ack_n, "R6 no ack without chip select", ack_n, 1);
    end
    strb = 1'b0;
    bus_xfer(1'b1, 6'h00, 8'h00, 0, q, lat, oe);
    chk(q == 8'h13, "R6 control unchanged without chip select", q, 8'h13);

    // R9 processor-enable output
    bus_xfer(1'b0, 6'h00, 8'h5B, 0, q, lat, oe);
    chk(proc_en == 1'b1, "R9 proc_en set", proc_en, 1);
    bus_xfer(1'b0, 6'h00, 8'h1B, 0, q, lat, oe);
    chk(proc_en == 1'b0, "R9 proc_en clear", proc_en, 0);

    // R1 reset clears a programmed register
    bus_xfer(1'b0, 6'h00, 8'hDB, 0, q, lat, oe);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(proc_en == 1'b0, "R1 proc_en cleared by reset", proc_en, 0);
    bus_xfer(1'b1, 6'h00, 8'h00, 0, q, lat, oe);
    chk(q == 8'h00, "R1 register cleared by reset", q, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule